// File: doc/BRIEF.md
# Keyed Write-Protection Gate

This block sits in front of a bank of configuration registers and decides, write by write, whether a store into that bank may go through. A lock bit held in a control word gates every write aimed at the guarded offset window. Software can only change that bit by writing the control word with a fixed 24-bit key value in its upper bits. Without the key the write leaves the lock bit unchanged.

While the lock is on, a write into the guarded window is dropped. A log word records that a write was refused and which offset it aimed at. Reading the log returns its contents and clears the refusal flag, but the logged offset is kept until the next refusal. When the lock is off, guarded writes pass, and an accept strobe tells the register bank to store the data. The bus has separate read and write addresses, so a read and a write can be presented in the same cycle. Read data is registered.

Top module: `keyed_wr_guard`

## Requirements
- R1: After reset the lock bit, the refusal flag and the logged offset are all zero, and the read data output is zero.
- R2: A write to the control offset (0x40) whose bits 31:8 equal 0x534D43 loads bit 0 of the write data into the lock bit.
- R3: A write to the control offset whose bits 31:8 differ from 0x534D43 leaves the lock bit unchanged.
- R4: A read of the control offset returns the lock bit in bit 0 and zero in every other bit, so the key never reads back.
- R5: While the lock bit is set, a write to a guarded offset (0x00 to 0x1F) gives no accept strobe. It sets the refusal flag and logs the offset, zero-extended into the 16-bit source field. The log word (offset 0x41) reads the flag in bit 0 and the source in bits 23:8.
- R6: While the lock bit is clear, a write to a guarded offset raises the accept strobe in that same cycle and does not touch the log.
- R7: A read of the log word returns the flag and source as they stood before the read, then clears the flag and keeps the source.
- R8: When a refused write and a log read fall in the same cycle, the read returns the earlier contents. Afterwards the flag stays set and the source holds the new offset.
- R9: Writes to the control offset are never refused. Writes to the log offset or to offsets outside the guarded window give no accept strobe and change neither the flag nor the source.
- R10: A later refusal overwrites the logged source with the later offset. This covers both ends of the guarded window.
- R11: Read data appears the cycle after the read request and is zero in a cycle that follows no read request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write request |
| wr_addr | input | 8 | Write offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read request |
| rd_addr | input | 8 | Read offset |
| rd_data | output | 32 | Registered read data |
| wr_accept | output | 1 | Guarded write allowed this cycle |

## Verification
Two functions can meet in one cycle: a refused write sets the refusal flag while a log read clears it. The bench provokes this by locking the gate, leaving one refusal logged, and then presenting a guarded write and a log read on the same clock. The read must return the older word. A following read must then show the flag still set with the newer offset, and a third read must show it cleared.

// File: rtl/kwg_pkg.sv
package kwg_pkg;
    localparam int          WORD_W     = 32;
    localparam int          KEY_W      = 24;
    localparam int          KEY_LO     = 8;
    localparam int          LOCK_BIT   = 0;
    localparam int          FLAG_BIT   = 0;
    localparam int          SRC_LO     = 8;
    localparam logic [KEY_W-1:0] UNLOCK_KEY = 24'h534D43;

    typedef enum logic [1:0] {
        RSEL_NONE = 2'd0,
        RSEL_CTRL = 2'd1,
        RSEL_LOG  = 2'd2
    } rsel_e;
endpackage

// File: rtl/kwg_decode.sv
module kwg_decode #(
    parameter int ADDR_W     = 8,
    parameter int CTRL_OFS   = 8'h40,
    parameter int LOG_OFS    = 8'h41,
    parameter int GUARD_BASE = 0,
    parameter int GUARD_CNT  = 32
) (
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic              ctrl_wr_o,
    output logic              guard_wr_o,
    output kwg_pkg::rsel_e    rsel_o
);
    localparam logic [ADDR_W-1:0] CTRL_A  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] LOG_A   = ADDR_W'(LOG_OFS);
    localparam logic [ADDR_W-1:0] G_LO    = ADDR_W'(GUARD_BASE);
    localparam logic [ADDR_W-1:0] G_HI    = ADDR_W'(GUARD_BASE + GUARD_CNT);

    logic in_window;

    generate
        if (GUARD_BASE == 0) begin : g_from_zero
            assign in_window = (wr_addr_i < G_HI);
        end else begin : g_range
            assign in_window = (wr_addr_i >= G_LO) && (wr_addr_i < G_HI);
        end
    endgenerate

    always_comb begin
        ctrl_wr_o  = wr_en_i && (wr_addr_i == CTRL_A);
        guard_wr_o = wr_en_i && in_window;
        rsel_o     = kwg_pkg::RSEL_NONE;
        if (rd_en_i) begin
            if (rd_addr_i == CTRL_A)      rsel_o = kwg_pkg::RSEL_CTRL;
            else if (rd_addr_i == LOG_A)  rsel_o = kwg_pkg::RSEL_LOG;
        end
    end
endmodule

// File: rtl/kwg_lock.sv
module kwg_lock
    import kwg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic              lock_o
);
    typedef struct packed {
        logic lock;
    } lock_st_t;

    lock_st_t st_d, st_q;
    logic     key_ok;
    logic     unused_bits;

    assign unused_bits = ^wdata_i[KEY_LO-1:LOCK_BIT+1];
    assign key_ok      = (wdata_i[KEY_LO +: KEY_W] == UNLOCK_KEY);

    always_comb begin
        st_d = st_q;
        if (ctrl_wr_i && key_ok) st_d.lock = wdata_i[LOCK_BIT];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lock_o = st_q.lock;

    // R3: a keyless control write leaves the lock bit alone
    a_r3_bad_key_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && (wdata_i[KEY_LO +: KEY_W] != UNLOCK_KEY)) |=> $stable(lock_o));
    // R2: a keyed control write lands bit 0 in the lock bit
    a_r2_key_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && (wdata_i[KEY_LO +: KEY_W] == UNLOCK_KEY)) |=> (lock_o == $past(wdata_i[LOCK_BIT])));
endmodule

// File: rtl/kwg_log.sv
module kwg_log #(
    parameter int ADDR_W = 8,
    parameter int SRC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              refuse_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              clear_i,
    output logic              flag_o,
    output logic [SRC_W-1:0]  src_o
);
    typedef struct packed {
        logic             flag;
        logic [SRC_W-1:0] src;
    } log_st_t;

    log_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clear_i)  st_d.flag = 1'b0;
        if (refuse_i) begin
            st_d.flag = 1'b1;
            st_d.src  = SRC_W'(addr_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign src_o  = st_q.src;

    // R5 / R8: a refusal always leaves the flag set, even against a clearing read
    a_r5_refuse_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        refuse_i |=> flag_o);
    // R7: a clearing read with no refusal drops the flag
    a_r7_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !refuse_i) |=> !flag_o);
    // R10: the source only moves on a refusal
    a_r10_src_only_on_refuse: assert property (@(posedge clk) disable iff (!rst_n)
        !refuse_i |=> $stable(src_o));
endmodule

// File: rtl/keyed_wr_guard.sv
module keyed_wr_guard
    import kwg_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int SRC_W      = 16,
    parameter int CTRL_OFS   = 8'h40,
    parameter int LOG_OFS    = 8'h41,
    parameter int GUARD_BASE = 0,
    parameter int GUARD_CNT  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic              wr_accept
);
    typedef struct packed {
        logic [WORD_W-1:0] rdata;
    } rd_st_t;

    logic             ctrl_wr, guard_wr, lock, refuse, flag;
    logic [SRC_W-1:0] src;
    rsel_e            rsel;
    rd_st_t           rd_d, rd_q;

    kwg_decode #(
        .ADDR_W(ADDR_W), .CTRL_OFS(CTRL_OFS), .LOG_OFS(LOG_OFS),
        .GUARD_BASE(GUARD_BASE), .GUARD_CNT(GUARD_CNT)
    ) u_dec (
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .ctrl_wr_o(ctrl_wr), .guard_wr_o(guard_wr), .rsel_o(rsel)
    );

    kwg_lock u_lock (
        .clk(clk), .rst_n(rst_n), .ctrl_wr_i(ctrl_wr), .wdata_i(wr_data), .lock_o(lock)
    );

    assign refuse    = guard_wr && lock;
    assign wr_accept = guard_wr && !lock;

    kwg_log #(.ADDR_W(ADDR_W), .SRC_W(SRC_W)) u_log (
        .clk(clk), .rst_n(rst_n), .refuse_i(refuse), .addr_i(wr_addr),
        .clear_i(rsel == RSEL_LOG), .flag_o(flag), .src_o(src)
    );

    always_comb begin
        rd_d = '0;
        case (rsel)
            RSEL_CTRL: rd_d.rdata[LOCK_BIT] = lock;
            RSEL_LOG: begin
                rd_d.rdata[FLAG_BIT]         = flag;
                rd_d.rdata[SRC_LO +: SRC_W]  = src;
            end
            default: rd_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;

    // R6: an accepted guarded write leaves the log untouched
    a_r6_accept_keeps_log: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && rsel != RSEL_LOG) |=> ($stable(src) && $stable(flag)));
    // R4: a control read never shows anything above bit 0
    a_r4_ctrl_read_clean: assert property (@(posedge clk) disable iff (!rst_n)
        (rsel == RSEL_CTRL) |=> (rd_data[31:1] == '0));
    // R11: no read request means zero data next cycle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> (rd_data == '0));
endmodule

// File: tb/sim_keyed_wr_guard.sv
`timescale 1ns/1ps
module sim_keyed_wr_guard;
    localparam logic [7:0]  CTRL = 8'h40;
    localparam logic [7:0]  LOGW = 8'h41;
    localparam logic [31:0] KEY  = 32'h534D4300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        wr_accept;

    int n_chk = 0, n_bad = 0;
    logic        issued = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    bit          done = 0;

    always #2 clk = ~clk;

    keyed_wr_guard u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_accept(wr_accept)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one bus cycle; an expected read result goes to the scoreboard queue
    task automatic op(input logic we, input logic [7:0] wa, input logic [31:0] wd,
                      input logic re, input logic [7:0] ra, input logic [31:0] rexp,
                      input string tag);
        @(negedge clk);
        wr_en = we; wr_addr = wa; wr_data = wd;
        rd_en = re; rd_addr = ra;
        if (re) begin
            exp_q.push_back(rexp);
            tag_q.push_back(tag);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic acc, input string tag);
        op(1'b1, a, d, 1'b0, 8'h0, 32'h0, tag);
        #1 check(tag, {31'b0, wr_accept}, {31'b0, acc});
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        op(1'b0, 8'h0, 32'h0, 1'b1, a, exp, tag);
    endtask

    // monitor: note a request at the edge, compare half a cycle later
    always @(posedge clk) issued <= rd_en && rst_n;
    always @(negedge clk) begin
        if (issued) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 actual=%h expected=none", rd_data);
            end else check(tag_q.pop_front(), rd_data, exp_q.pop_front());
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 rdata in reset", rd_data, 32'h0);
        rst_n = 1'b1;
        rd(CTRL, 32'h0, "R1 lock clear");
        rd(LOGW, 32'h0, "R1 log clear");

        wr(8'h05, 32'hAAAA5555, 1'b1, "R6 accept while unlocked");
        rd(LOGW, 32'h0, "R6 log untouched");

        wr(CTRL, 32'h12345601, 1'b0, "R9 ctrl write no accept");
        rd(CTRL, 32'h0, "R3 bad key ignored");

        wr(CTRL, KEY | 32'h1, 1'b0, "R2 keyed lock write");
        rd(CTRL, 32'h1, "R2 R4 lock set, key reads zero");

        wr(8'h07, 32'h1, 1'b0, "R5 refused no accept");
        rd(LOGW, 32'h00000701, "R5 log flag and source");
        rd(LOGW, 32'h00000700, "R7 flag cleared, source kept");

        wr(8'h30, 32'h1, 1'b0, "R9 outside window no accept");
        wr(LOGW, 32'hFFFFFFFF, 1'b0, "R9 log write no accept");
        rd(LOGW, 32'h00000700, "R9 log unchanged");

        wr(8'h1F, 32'h0, 1'b0, "R10 top of window refused");
        rd(LOGW, 32'h00001F01, "R10 source overwritten");
        wr(8'h20, 32'h0, 1'b0, "R10 first outside offset");
        rd(LOGW, 32'h00001F00, "R10 outside offset not logged");
        wr(8'h00, 32'h0, 1'b0, "R10 bottom of window refused");
        rd(LOGW, 32'h00000001, "R10 offset zero logged");

        wr(8'h02, 32'h0, 1'b0, "R8 first refusal");
        op(1'b1, 8'h03, 32'h0, 1'b1, LOGW, 32'h00000201, "R8 same-cycle read gets older word");
        #1 check("R8 refused no accept", {31'b0, wr_accept}, 32'h0);
        rd(LOGW, 32'h00000301, "R8 flag survives, new source");
        rd(LOGW, 32'h00000300, "R8 then cleared");

        wr(CTRL, 32'h00000000, 1'b0, "R9 wrong key while locked");
        rd(CTRL, 32'h1, "R3 lock held");
        wr(CTRL, KEY, 1'b0, "R9 unlock never refused");
        rd(CTRL, 32'h0, "R2 lock cleared");
        wr(8'h04, 32'h0, 1'b1, "R6 accept after unlock");
        rd(LOGW, 32'h00000300, "R6 log untouched after unlock");

        op(1'b0, 8'h0, 32'h0, 1'b0, 8'h0, 32'h0, "idle");
        @(negedge clk); #1;
        check("R11 zero after idle", rd_data, 32'h0);
        repeat (2) @(negedge clk);
        check("R11 scoreboard drained", 32'(exp_q.size()), 32'h0);
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule